// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block sits between the interrupt sources of a small microcontroller and its CPU. It gathers requests into 32 priority slots and picks the highest one that its enables allow. It then presents the slot number and the word address of that slot's vector. Vectors fill the top 64 bytes of the 16-bit address space. Slot 31 is the highest priority and its vector sits at 0xFFFE. Each lower slot sits two bytes lower, so slot 0 is at 0xFFC0. Several sources may share one slot, and a shared slot stays pending while any of its sources is still asserted.

Masking depends on the slot. Slot 31 is the reset slot and ignores every enable. Slot 30 can be blocked only by its own enable bit. Every other slot needs both its own enable and the global enable. The global enable is held inside the block. The CPU sets it and clears it through strobes, and an acknowledge from the CPU also clears it. While acknowledge is high, the presented vector is frozen.

Two checks on the CPU's bus also feed the block. An instruction fetch from the peripheral register region (0x0000 to 0x01FF) raises a reset request, and that request also becomes pending in the reset slot. A reset-vector word that reads as all ones marks the system for the deepest sleep mode until the next reset.

Top module: `irq_vector_arbiter`

## Requirements
- R1: With rst_n low at a clock edge, every output becomes 0 at that edge: irq_o, slot_o, vec_addr_o, gie_o, fetch_rst_o and deep_sleep_o.
- R2: At each edge where ack_i is low, irq_o and slot_o take the highest-numbered eligible slot from the inputs sampled at that edge. The result is therefore visible one cycle after the request set changes.
- R3: When irq_o is 1, vec_addr_o equals 0xFFC0 + 2 × slot_o, so slot 31 gives 0xFFFE and slot 0 gives 0xFFC0.
- R4: Slot 31 is eligible whenever it is pending, whatever slot_en_i[31] and the global enable hold.
- R5: Slot 30 is eligible when it is pending and slot_en_i[30] is 1, whatever the global enable holds. It is never eligible while slot_en_i[30] is 0.
- R6: Slots 0 to 29 are eligible only when pending, with their slot_en_i bit at 1 and the global enable (gie_o) at 1 at that edge.
- R7: Slot s is pending when any of src_req_i[4s+3:4s] is 1.
- R8: At an edge, gie_clr_i or ack_i clears the global enable, and gie_set_i sets it only when neither clear is present. gie_o shows the new value from the next cycle.
- R9: At any edge where ack_i is 1, irq_o, slot_o and vec_addr_o keep their previous values.
- R10: A fetch (fetch_valid_i = 1) from an address at or below 0x01FF makes fetch_rst_o 1 in the next cycle. That pulse also counts as a pending request of slot 31 at the following edge. Fetches from 0x0200 and above do nothing.
- R11: rstvec_valid_i = 1 with rstvec_data_i = 0xFFFF sets deep_sleep_o from the next cycle, and it stays set until reset. Any other word leaves it unchanged.
- R12: When no slot is eligible at an edge where ack_i is low, irq_o, slot_o and vec_addr_o become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_req_i | input | 128 | Request sources, four per slot; bit 4s+j is source j of slot s |
| slot_en_i | input | 32 | Individual enable per slot |
| gie_set_i | input | 1 | Set the global enable |
| gie_clr_i | input | 1 | Clear the global enable |
| ack_i | input | 1 | CPU acknowledge: clears the global enable and freezes the vector |
| fetch_valid_i | input | 1 | An instruction fetch is on the bus this cycle |
| fetch_addr_i | input | 16 | Byte address of that fetch |
| rstvec_valid_i | input | 1 | The reset-vector word is on rstvec_data_i this cycle |
| rstvec_data_i | input | 16 | Word read from the reset vector |
| irq_o | output | 1 | A slot has been selected |
| slot_o | output | 5 | Selected slot number |
| vec_addr_o | output | 16 | Word address of the selected vector |
| gie_o | output | 1 | Global enable state |
| fetch_rst_o | output | 1 | Reset request caused by an illegal fetch |
| deep_sleep_o | output | 1 | The erased reset vector was seen; the system enters deepest sleep |

## Verification
The assertions check on every cycle the properties that hold in any state:
- the address always matches the slot;
- the idle outputs are zero;
- acknowledge freezes the vector and clears the global enable;
- a pending reset slot always wins;
- a selected slot 30 had its own enable, and a selected ordinary slot had the global enable;
- an illegal fetch pulses the reset request;
- the deep-sleep flag is sticky.

Only the bench scenarios can show the rest: the right slot wins among several pending slots, a source in a shared slot pulls that slot, masked slots stay silent, the reset slot takes over after an illegal fetch, and only the all-ones reset word arms deep sleep.

// File: rtl/ivc_pkg.sv
// Shared types for the interrupt vector controller.
// Assumes the two highest slots are the reset slot and the
// individually-maskable slot; all others are fully maskable.
package ivc_pkg;

    typedef enum logic [1:0] {
        CLS_RESET    = 2'd0,
        CLS_INDIV    = 2'd1,
        CLS_MASKABLE = 2'd2
    } slot_class_e;

    // Masking class of slot index s in a controller with n slots
    function automatic slot_class_e class_of(input int s, input int n);
        if (s == n - 1)      return CLS_RESET;
        else if (s == n - 2) return CLS_INDIV;
        else                 return CLS_MASKABLE;
    endfunction

endpackage

// File: rtl/ivc_src_merge.sv
// Merges the request sources of each slot into one pending bit.
// Assumes every slot owns SRC_PER_SLOT adjacent source bits.
module ivc_src_merge #(
    parameter int NUM_SLOTS    = 32,
    parameter int SRC_PER_SLOT = 4
) (
    input  logic [NUM_SLOTS*SRC_PER_SLOT-1:0] src_i,
    output logic [NUM_SLOTS-1:0]              pend_o
);

    // One OR-reduction per slot
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign pend_o[s] = |src_i[s*SRC_PER_SLOT +: SRC_PER_SLOT];
    end

endmodule

// File: rtl/ivc_mask.sv
// Applies the per-slot masking class to the pending bits.
// Assumes gie_i is the registered global enable of the current cycle.
module ivc_mask
    import ivc_pkg::*;
#(
    parameter int NUM_SLOTS = 32
) (
    input  logic [NUM_SLOTS-1:0] pend_i,
    input  logic [NUM_SLOTS-1:0] en_i,
    input  logic                 gie_i,
    output logic [NUM_SLOTS-1:0] elig_o
);

    // Select the masking rule for each slot from its class
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam slot_class_e CLS = class_of(s, NUM_SLOTS);
        if (CLS == CLS_RESET) begin : g_reset
            logic unused_reset_en;
            assign unused_reset_en = en_i[s];
            assign elig_o[s] = pend_i[s];
        end else if (CLS == CLS_INDIV) begin : g_indiv
            assign elig_o[s] = pend_i[s] & en_i[s];
        end else begin : g_full
            assign elig_o[s] = pend_i[s] & en_i[s] & gie_i;
        end
    end

endmodule

// File: rtl/ivc_prio_enc.sv
// Finds the highest set bit of the eligible vector.
// Assumes NUM_SLOTS fits in SLOT_W bits; idx_o is 0 when none is set.
module ivc_prio_enc #(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] elig_i,
    output logic                 found_o,
    output logic [SLOT_W-1:0]    idx_o
);

    // Scan upward so the highest eligible index is kept last
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (elig_i[i]) begin
                found_o = 1'b1;
                idx_o   = i[SLOT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/ivc_fetch_guard.sv
// Watches instruction fetches for the peripheral region and the
// reset-vector word for the erased (all ones) pattern.
// Assumes one fetch and one reset-vector read per cycle at most.
module ivc_fetch_guard #(
    parameter int ADDR_W     = 16,
    parameter int PERIPH_TOP = 'h01FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic              rstvec_valid_i,
    input  logic [ADDR_W-1:0] rstvec_data_i,
    output logic              fetch_rst_o,
    output logic              deep_sleep_o
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(PERIPH_TOP);

    logic illegal_fetch;
    logic erased_vec;

    assign illegal_fetch = fetch_valid_i && (fetch_addr_i <= TOP_ADDR);
    assign erased_vec    = rstvec_valid_i && (rstvec_data_i == '1);

    // Register a one-cycle reset request per illegal fetch
    always_ff @(posedge clk) begin
        if (!rst_n) fetch_rst_o <= 1'b0;
        else        fetch_rst_o <= illegal_fetch;
    end

    // Hold the deep-sleep flag from the erased vector until reset
    always_ff @(posedge clk) begin
        if (!rst_n)          deep_sleep_o <= 1'b0;
        else if (erased_vec) deep_sleep_o <= 1'b1;
    end

    a_r10_fetch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && fetch_addr_i <= TOP_ADDR) |=> fetch_rst_o);

    a_r11_sleep_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep_o |=> deep_sleep_o);

endmodule

// File: rtl/irq_vector_arbiter.sv
// Fixed-priority interrupt vector controller. It merges the sources,
// masks them by class, picks the highest slot and registers the slot and
// its vector address. It owns the global enable and the fetch guard.
// Assumes the vectors fill the top 2*NUM_SLOTS bytes of the address space.
module irq_vector_arbiter #(
    parameter int NUM_SLOTS    = 32,
    parameter int SRC_PER_SLOT = 4,
    parameter int ADDR_W       = 16,
    parameter int PERIPH_TOP   = 'h01FF,
    localparam int SLOT_W      = $clog2(NUM_SLOTS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SLOTS*SRC_PER_SLOT-1:0] src_req_i,
    input  logic [NUM_SLOTS-1:0]             slot_en_i,
    input  logic                             gie_set_i,
    input  logic                             gie_clr_i,
    input  logic                             ack_i,
    input  logic                             fetch_valid_i,
    input  logic [ADDR_W-1:0]                fetch_addr_i,
    input  logic                             rstvec_valid_i,
    input  logic [ADDR_W-1:0]                rstvec_data_i,
    output logic                             irq_o,
    output logic [SLOT_W-1:0]                slot_o,
    output logic [ADDR_W-1:0]                vec_addr_o,
    output logic                             gie_o,
    output logic                             fetch_rst_o,
    output logic                             deep_sleep_o
);

    localparam int RESET_SLOT = NUM_SLOTS - 1;
    localparam int INDIV_SLOT = NUM_SLOTS - 2;
    localparam logic [ADDR_W-1:0] VEC_BASE =
        ADDR_W'((1 << ADDR_W) - 2 * NUM_SLOTS);

    logic [NUM_SLOTS-1:0] src_pend;
    logic [NUM_SLOTS-1:0] pend;
    logic [NUM_SLOTS-1:0] elig;
    logic                 win_found;
    logic [SLOT_W-1:0]    win_idx;
    logic [ADDR_W-1:0]    win_addr;

    ivc_src_merge #(
        .NUM_SLOTS    (NUM_SLOTS),
        .SRC_PER_SLOT (SRC_PER_SLOT)
    ) u_merge (
        .src_i  (src_req_i),
        .pend_o (src_pend)
    );

    // Fold the illegal-fetch reset request into the reset slot
    always_comb begin
        pend             = src_pend;
        pend[RESET_SLOT] = src_pend[RESET_SLOT] | fetch_rst_o;
    end

    ivc_mask #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_mask (
        .pend_i (pend),
        .en_i   (slot_en_i),
        .gie_i  (gie_o),
        .elig_o (elig)
    );

    ivc_prio_enc #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_enc (
        .elig_i  (elig),
        .found_o (win_found),
        .idx_o   (win_idx)
    );

    ivc_fetch_guard #(
        .ADDR_W     (ADDR_W),
        .PERIPH_TOP (PERIPH_TOP)
    ) u_guard (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_valid_i  (fetch_valid_i),
        .fetch_addr_i   (fetch_addr_i),
        .rstvec_valid_i (rstvec_valid_i),
        .rstvec_data_i  (rstvec_data_i),
        .fetch_rst_o    (fetch_rst_o),
        .deep_sleep_o   (deep_sleep_o)
    );

    // Vector word address of the winning slot
    assign win_addr = VEC_BASE + ADDR_W'({win_idx, 1'b0});

    // Global enable: clears win over set
    always_ff @(posedge clk) begin
        if (!rst_n)                  gie_o <= 1'b0;
        else if (gie_clr_i || ack_i) gie_o <= 1'b0;
        else if (gie_set_i)          gie_o <= 1'b1;
    end

    // Register the arbitration result unless the CPU is acknowledging
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o      <= 1'b0;
            slot_o     <= '0;
            vec_addr_o <= '0;
        end else if (!ack_i) begin
            irq_o      <= win_found;
            slot_o     <= win_found ? win_idx : '0;
            vec_addr_o <= win_found ? win_addr : '0;
        end
    end

    a_r3_addr_tracks_slot: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> vec_addr_o == VEC_BASE + ADDR_W'({slot_o, 1'b0}));

    a_r12_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (slot_o == '0 && vec_addr_o == '0));

    a_r9_ack_freezes_vector: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> ($stable(irq_o) && $stable(slot_o) && $stable(vec_addr_o)));

    a_r8_ack_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !gie_o);

    a_r4_reset_slot_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[RESET_SLOT] && !ack_i) |=> (irq_o && slot_o == SLOT_W'(RESET_SLOT)));

    a_r5_indiv_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && slot_o == SLOT_W'(INDIV_SLOT) && !$past(ack_i))
            |-> $past(slot_en_i[INDIV_SLOT]));

    a_r6_ordinary_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && slot_o < SLOT_W'(INDIV_SLOT) && !$past(ack_i)) |-> $past(gie_o));

endmodule

// File: tb/irq_vector_arbiter_test.sv
`timescale 1ns/1ps
module irq_vector_arbiter_test;

    localparam int NS  = 32;
    localparam int SPS = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS*SPS-1:0] src = '0;
    logic [NS-1:0]     ien = '0;
    logic              gset = 1'b0, gclr = 1'b0, ack = 1'b0;
    logic              fvalid = 1'b0;
    logic [15:0]       faddr = 16'h8000;
    logic              rvvalid = 1'b0;
    logic [15:0]       rvdata = 16'h0000;

    logic              irq, gie, frst, sleep;
    logic [4:0]        slot;
    logic [15:0]       vaddr;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    irq_vector_arbiter uut (
        .clk(clk), .rst_n(rst_n), .src_req_i(src), .slot_en_i(ien),
        .gie_set_i(gset), .gie_clr_i(gclr), .ack_i(ack),
        .fetch_valid_i(fvalid), .fetch_addr_i(faddr),
        .rstvec_valid_i(rvvalid), .rstvec_data_i(rvdata),
        .irq_o(irq), .slot_o(slot), .vec_addr_o(vaddr), .gie_o(gie),
        .fetch_rst_o(frst), .deep_sleep_o(sleep)
    );

    // Behavioural reference model, advanced on every rising edge
    logic        m_irq = 0, m_gie = 0, m_frst = 0, m_sleep = 0;
    logic [4:0]  m_slot = 0;
    logic [15:0] m_addr = 0;

    always @(posedge clk) begin
        int  win;
        logic p, e;
        win = -1;
        for (int s = NS - 1; s >= 0; s--) begin
            p = |src[s*SPS +: SPS];
            if (s == NS - 1) p = p | m_frst;
            if (s == NS - 1)      e = p;
            else if (s == NS - 2) e = p & ien[s];
            else                  e = p & ien[s] & m_gie;
            if (e && win < 0) win = s;
        end
        if (!rst_n) begin
            m_irq <= 0; m_slot <= 0; m_addr <= 0;
            m_gie <= 0; m_frst <= 0; m_sleep <= 0;
        end else begin
            if (gclr || ack) m_gie <= 0;
            else if (gset)   m_gie <= 1;
            m_frst <= fvalid && (faddr <= 16'h01FF);
            if (rvvalid && rvdata == 16'hFFFF) m_sleep <= 1;
            if (!ack) begin
                m_irq  <= (win >= 0);
                m_slot <= (win >= 0) ? 5'(win) : 5'd0;
                m_addr <= (win >= 0) ? 16'hFFC0 + 16'(2 * win) : 16'h0000;
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Compare every output with the model away from the rising edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2",  "model irq",   32'(irq),   32'(m_irq));
            chk("R2",  "model slot",  32'(slot),  32'(m_slot));
            chk("R3",  "model addr",  32'(vaddr), 32'(m_addr));
            chk("R8",  "model gie",   32'(gie),   32'(m_gie));
            chk("R10", "model frst",  32'(frst),  32'(m_frst));
            chk("R11", "model sleep", 32'(sleep), 32'(m_sleep));
        end
    end

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_vec(input string tag, input logic e_irq,
                              input int e_slot);
        chk(tag, "irq",  32'(irq),   32'(e_irq));
        chk(tag, "slot", 32'(slot),  32'(e_slot));
        chk(tag, "addr", 32'(vaddr), e_irq ? 32'(16'hFFC0 + 2 * e_slot) : 32'h0);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        cmp_on = 1'b1;
        // R1: reset state
        chk("R1", "irq", 32'(irq), 0);
        chk("R1", "gie", 32'(gie), 0);
        chk("R1", "sleep", 32'(sleep), 0);
        rst_n = 1'b1;
        tick();
        expect_vec("R12", 0, 0);

        // R6: ordinary slot blocked while global enable is low
        src[5*SPS] = 1'b1; ien[5] = 1'b1;
        tick();
        expect_vec("R6", 0, 0);
        gset = 1'b1;
        tick();
        gset = 1'b0;
        chk("R8", "gie set", 32'(gie), 1);
        tick();
        expect_vec("R6", 1, 5);

        // R7: source 2 of slot 17 pulls the slot; R2 higher slot wins
        src[17*SPS+2] = 1'b1; ien[17] = 1'b1;
        tick();
        expect_vec("R7", 1, 17);

        // R5: slot 30 needs its own enable only
        src[30*SPS+3] = 1'b1; ien[30] = 1'b0;
        tick();
        expect_vec("R5", 1, 17);
        gclr = 1'b1;
        tick();
        gclr = 1'b0;
        chk("R8", "gie clear", 32'(gie), 0);
        tick();
        expect_vec("R6", 0, 0);
        ien[30] = 1'b1;
        tick();
        expect_vec("R5", 1, 30);

        // R4: reset slot ignores both enables
        src[31*SPS+1] = 1'b1; ien[31] = 1'b0;
        tick();
        expect_vec("R4", 1, 31);

        // R3: lowest slot address
        src = '0; src[0] = 1'b1; ien[0] = 1'b1; gset = 1'b1;
        tick();
        gset = 1'b0;
        tick();
        expect_vec("R3", 1, 0);

        // R9: acknowledge freezes the vector and clears the global enable
        src[17*SPS+2] = 1'b1;
        tick();
        expect_vec("R2", 1, 17);
        ack = 1'b1; src[31*SPS] = 1'b1;
        tick();
        expect_vec("R9", 1, 17);
        chk("R8", "ack clears gie", 32'(gie), 0);
        tick();
        expect_vec("R9", 1, 17);
        ack = 1'b0;
        tick();
        expect_vec("R4", 1, 31);
        src = '0;
        tick();
        expect_vec("R12", 0, 0);

        // R10: illegal fetch raises reset and pends the reset slot
        fvalid = 1'b1; faddr = 16'h0200;
        tick();
        chk("R10", "legal fetch", 32'(frst), 0);
        faddr = 16'h01FF;
        tick();
        fvalid = 1'b0;
        chk("R10", "illegal fetch", 32'(frst), 1);
        tick();
        chk("R10", "pulse ends", 32'(frst), 0);
        expect_vec("R10", 1, 31);
        tick();
        expect_vec("R12", 0, 0);

        // R11: only the erased reset vector arms deep sleep
        rvvalid = 1'b1; rvdata = 16'h1234;
        tick();
        chk("R11", "normal vector", 32'(sleep), 0);
        rvdata = 16'hFFFF;
        tick();
        rvvalid = 1'b0;
        chk("R11", "erased vector", 32'(sleep), 1);
        tick(); tick();
        chk("R11", "sticky", 32'(sleep), 1);
        rst_n = 1'b0;
        tick();
        chk("R1", "sleep cleared by reset", 32'(sleep), 0);
        rst_n = 1'b1;

        // Mixed traffic checked against the model on every cycle
        for (int k = 0; k < 400; k++) begin
            for (int w = 0; w < 4; w++)
                src[w*32 +: 32] = $urandom & $urandom & $urandom;
            ien     = $urandom;
            gset    = ($urandom % 4) == 0;
            gclr    = ($urandom % 6) == 0;
            ack     = ($urandom % 5) == 0;
            fvalid  = ($urandom % 3) == 0;
            faddr   = (($urandom % 8) == 0) ? 16'($urandom % 16'h0300) : 16'($urandom);
            rvvalid = ($urandom % 50) == 0;
            rvdata  = (($urandom % 2) == 0) ? 16'hFFFF : 16'($urandom);
            tick();
        end
        finish_run();
    end

endmodule